// File: doc/BRIEF.md
# USB Slave-FIFO Transmit Engine

This block drains a local first-word-fall-through transmit FIFO into the slave-FIFO port of an external USB controller. It runs entirely in the interface clock domain. When the local FIFO has data and the controller reports that it can take it, the engine moves into its write state. It pops bytes with a read enable, drives each byte onto the shared data bus, and pulses an active-low write strobe. The strobe follows the FIFO's valid output, which rises one clock after the read enable.

Three controller flags gate the transfer. Two ready flags must both be high, and the full flag must be low. If the full flag rises while a popped byte is already on its way, the engine keeps that byte in a one-entry stall register and writes it once the flag clears. If the local FIFO runs dry, the engine returns to idle and releases the bus. The FIFO address outputs constantly select the IN endpoint buffer.

Top module: `usbtx_engine`

## Requirements
- R1: While `rst_n` is low, and until its release has passed through the synchronizer, `wr_n` is 1, `src_rd` is 0 and `bus_oe` is 0. Assertion of `rst_n` takes effect without waiting for a clock edge.
- R2: The engine leaves idle when `src_avail`=1, `ctl_rdy0`=1, `ctl_rdy1`=1 and `ctl_full`=0. `src_rd` is 1 in that same cycle, and `bus_oe` is 1 from the next cycle.
- R3: `src_rd` is 1 only while all four conditions of R2 hold. A low `ctl_rdy0` or `ctl_rdy1` starts no pop and no write.
- R4: `ctl_full`=1 means the controller buffer is full, and `wr_n` is never 0 while it is 1. A byte that arrives while it is 1 is held and written once `ctl_full` returns to 0, and no byte is lost.
- R5: Every popped byte is written exactly once, in pop order. `wr_n` is 0 for one cycle per byte, in the cycle after its pop, or later if the byte is held.
- R6: `bus_oe` is 1 only in the write state (state code 2'b01). During a strobe `bus_out` carries the byte being written, and `bus_out` is 0 while `bus_oe` is 0.
- R7: Once the FIFO is empty and no byte is held, the cycle after the last strobe shows `bus_oe`=0, `wr_n`=1 and `src_rd`=0.
- R8: `ep_sel` constantly equals the parameter `EP_IN_SEL`, which defaults to 2'b10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Interface clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| src_data | input | DATA_W | Local FIFO output byte |
| src_avail | input | 1 | Local FIFO holds at least one byte |
| src_vld | input | 1 | Local FIFO output valid, one clock after `src_rd` |
| src_rd | output | 1 | Local FIFO read enable |
| ctl_full | input | 1 | Controller transmit buffer full (1 = full) |
| ctl_rdy0 | input | 1 | Controller ready flag, first of two |
| ctl_rdy1 | input | 1 | Controller ready flag, second of two |
| bus_out | output | DATA_W | Data driven toward the shared bus |
| bus_oe | output | 1 | Bus output enable, pads tri-stated when 0 |
| wr_n | output | 1 | Active-low write strobe to the controller |
| ep_sel | output | ADDR_W | Controller FIFO address, IN endpoint buffer |

## Verification
The assertions check the per-cycle rules on every cycle. The strobe never falls while the full flag is high and always falls inside the write state. A pop only happens under the full gating condition and is followed by the bus being owned, and a strobe with fresh data puts that data on the bus. Only the bench scenarios can show end-to-end properties. These are that every pushed byte comes out once and in order across stalls, flag drops and refills, that a held byte survives a long full period, and that the engine falls back to idle after draining or after a reset in the middle of a burst.

// File: rtl/usbtx_pkg.sv
package usbtx_pkg;

  // Controller-side machine states; the write code is fixed at 2'b01.
  typedef enum logic [1:0] {
    ST_IDLE  = 2'b00,
    ST_WRITE = 2'b01
  } usbtx_state_e;

endpackage

// File: rtl/usbtx_rst_sync.sv
module usbtx_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic run
);

  if (STAGES == 0) begin : g_bypass
    assign run = rst_n;
  end else begin : g_chain
    logic [STAGES-1:0] sync_q;
    logic [STAGES:0]   shifted;

    assign shifted = {sync_q, 1'b1};

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        sync_q <= '0;
      end else begin
        sync_q <= shifted[STAGES-1:0];
      end
    end

    assign run = sync_q[STAGES-1];
  end

endmodule

// File: rtl/usbtx_ctrl.sv
module usbtx_ctrl
  import usbtx_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic src_avail,
  input  logic rdy0,
  input  logic rdy1,
  input  logic full,
  input  logic stall,
  output logic pop,
  output logic in_write
);

  usbtx_state_e state_q;
  usbtx_state_e state_d;
  logic         go;
  logic         state_en;

  // All gates for taking one more byte from the local FIFO.
  always_comb go = run & src_avail & rdy0 & rdy1 & ~full;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (go) state_d = ST_WRITE;
      ST_WRITE: if (!go && !stall) state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_comb state_en = (state_d != state_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
    end else if (state_en) begin
      state_q <= state_d;
    end
  end

  // The pop lands in the same cycle that the machine leaves idle.
  always_comb pop      = go;
  always_comb in_write = (state_q == ST_WRITE);

endmodule

// File: rtl/usbtx_hold.sv
module usbtx_hold #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_write,
  input  logic              vld,
  input  logic [DATA_W-1:0] data_in,
  input  logic              full,
  output logic [DATA_W-1:0] data_out,
  output logic              fire,
  output logic              stall
);

  logic              hold_v_q;
  logic [DATA_W-1:0] hold_d_q;
  logic              cur_v;
  logic              hold_en;
  logic              load_en;

  // A byte is present when fresh from the FIFO or parked from a full stall.
  always_comb cur_v    = hold_v_q | (vld & in_write);
  always_comb data_out = hold_v_q ? hold_d_q : data_in;
  always_comb fire     = in_write & cur_v & ~full;
  always_comb stall    = cur_v & full;
  always_comb hold_en  = hold_v_q | stall;
  always_comb load_en  = vld & in_write & full & ~hold_v_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_v_q <= 1'b0;
    end else if (hold_en) begin
      hold_v_q <= stall;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_d_q <= '0;
    end else if (load_en) begin
      hold_d_q <= data_in;
    end
  end

endmodule

// File: rtl/usbtx_engine.sv
module usbtx_engine
  import usbtx_pkg::*;
#(
  parameter int                 DATA_W      = 8,
  parameter int                 ADDR_W      = 2,
  parameter logic [ADDR_W-1:0]  EP_IN_SEL   = 2'b10,
  parameter int                 SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] src_data,
  input  logic              src_avail,
  input  logic              src_vld,
  output logic              src_rd,
  input  logic              ctl_full,
  input  logic              ctl_rdy0,
  input  logic              ctl_rdy1,
  output logic [DATA_W-1:0] bus_out,
  output logic              bus_oe,
  output logic              wr_n,
  output logic [ADDR_W-1:0] ep_sel
);

  localparam logic [DATA_W-1:0] BusIdle = '0;

  logic              run;
  logic              in_write;
  logic              stall;
  logic              fire;
  logic [DATA_W-1:0] byte_data;

  usbtx_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (run)
  );

  usbtx_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (run),
    .run       (run),
    .src_avail (src_avail),
    .rdy0      (ctl_rdy0),
    .rdy1      (ctl_rdy1),
    .full      (ctl_full),
    .stall     (stall),
    .pop       (src_rd),
    .in_write  (in_write)
  );

  usbtx_hold #(.DATA_W(DATA_W)) u_hold (
    .clk      (clk),
    .rst_n    (run),
    .in_write (in_write),
    .vld      (src_vld),
    .data_in  (src_data),
    .full     (ctl_full),
    .data_out (byte_data),
    .fire     (fire),
    .stall    (stall)
  );

  always_comb bus_oe  = in_write;
  always_comb bus_out = in_write ? byte_data : BusIdle;
  always_comb wr_n    = ~fire;
  always_comb ep_sel  = EP_IN_SEL;

endmodule

// File: rtl/usbtx_engine_sva.sv
module usbtx_engine_sva #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic [DATA_W-1:0] src_data,
  input logic              src_avail,
  input logic              src_vld,
  input logic              src_rd,
  input logic              ctl_full,
  input logic              ctl_rdy0,
  input logic              ctl_rdy1,
  input logic [DATA_W-1:0] bus_out,
  input logic              bus_oe,
  input logic              wr_n
);

  assert_no_strobe_when_full_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_n |-> !ctl_full);

  assert_strobe_inside_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_n |-> bus_oe);

  assert_pop_gated_R3: assert property (@(posedge clk) disable iff (!rst_n)
    src_rd |-> (src_avail && ctl_rdy0 && ctl_rdy1 && !ctl_full));

  assert_pop_then_own_bus_R2: assert property (@(posedge clk) disable iff (!rst_n)
    src_rd |=> bus_oe);

  assert_bus_entry_after_pop_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_oe) |-> $past(src_rd));

  assert_fresh_byte_on_bus_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_n && src_vld) |-> (bus_out == src_data));

  assert_held_byte_after_full_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_n && !src_vld) |-> $past(ctl_full));

endmodule

bind usbtx_engine usbtx_engine_sva #(.DATA_W(DATA_W)) u_sva (
  .clk       (clk),
  .rst_n     (rst_n),
  .src_data  (src_data),
  .src_avail (src_avail),
  .src_vld   (src_vld),
  .src_rd    (src_rd),
  .ctl_full  (ctl_full),
  .ctl_rdy0  (ctl_rdy0),
  .ctl_rdy1  (ctl_rdy1),
  .bus_out   (bus_out),
  .bus_oe    (bus_oe),
  .wr_n      (wr_n)
);

// File: tb/usbtx_engine_test.sv
module usbtx_engine_test;

  localparam int CLK_PERIOD = 10;
  localparam int NV         = 7;
  localparam int VCYC       = 60;

  // n_first, n_second, second_at, full_at, full_len, drop_at, drop_len
  localparam int VEC [NV][7] = '{
    '{4, 0,  0, -1, 0, -1, 0},
    '{6, 0,  0,  3, 4, -1, 0},
    '{5, 0,  0, -1, 0,  2, 5},
    '{3, 3, 20, -1, 0, -1, 0},
    '{8, 0,  0,  1, 1,  5, 2},
    '{1, 0,  0,  0, 6, -1, 0},
    '{2, 2, 10, 11, 3,  4, 2}
  };

  logic       clk = 1'b0;
  logic       rst_n;
  logic [7:0] src_data;
  logic       src_avail;
  logic       src_vld;
  logic       src_rd;
  logic       ctl_full;
  logic       ctl_rdy0;
  logic       ctl_rdy1;
  logic [7:0] bus_out;
  logic       bus_oe;
  logic       wr_n;
  logic [1:0] ep_sel;

  always #(CLK_PERIOD/2) clk = ~clk;

  usbtx_engine uut (
    .clk       (clk),
    .rst_n     (rst_n),
    .src_data  (src_data),
    .src_avail (src_avail),
    .src_vld   (src_vld),
    .src_rd    (src_rd),
    .ctl_full  (ctl_full),
    .ctl_rdy0  (ctl_rdy0),
    .ctl_rdy1  (ctl_rdy1),
    .bus_out   (bus_out),
    .bus_oe    (bus_oe),
    .wr_n      (wr_n),
    .ep_sel    (ep_sel)
  );

  // Local FIFO model: valid and data appear one clock after the read enable.
  logic [7:0] fm_mem [256];
  int         fm_head;
  int         fm_tail = 0;
  logic       fm_vld;
  logic [7:0] fm_q;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fm_vld  <= 1'b0;
      fm_q    <= 8'h00;
      fm_head <= fm_tail;
    end else begin
      fm_vld <= src_rd;
      if (src_rd) begin
        fm_q    <= fm_mem[fm_head % 256];
        fm_head <= fm_head + 1;
      end
    end
  end

  assign src_avail = (fm_head != fm_tail);
  assign src_vld   = fm_vld;
  assign src_data  = fm_q;

  // Controller-side monitor: records strobed bytes against the pushed order.
  logic [7:0] exp_q [256];
  int exp_n     = 0;
  int cap_n     = 0;
  int bad_order = 0;
  int bad_full  = 0;
  int bad_gate  = 0;

  always @(posedge clk) begin
    if (rst_n) begin
      if (!wr_n) begin
        if (cap_n >= 256 || bus_out !== exp_q[cap_n]) bad_order <= bad_order + 1;
        if (ctl_full) bad_full <= bad_full + 1;
        cap_n <= cap_n + 1;
      end
      if (src_rd && (!ctl_rdy0 || !ctl_rdy1 || ctl_full || !src_avail))
        bad_gate <= bad_gate + 1;
    end
  end

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic push(input logic [7:0] b);
    fm_mem[fm_tail % 256] = b;
    exp_q[exp_n % 256]    = b;
    exp_n++;
    fm_tail = fm_tail + 1;
  endtask

  task automatic push_n(input int n, input int seed);
    for (int i = 0; i < n; i++) push(8'((seed * 29 + i * 13 + 7) & 255));
  endtask

  function automatic int idle_code();
    return {29'd0, wr_n, bus_oe, src_rd};
  endfunction

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      n_fail++;
      n_tests++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    int base_cap, base_ord, base_full, base_gate;
    rst_n    = 1'b0;
    ctl_full = 1'b0;
    ctl_rdy0 = 1'b1;
    ctl_rdy1 = 1'b1;
    repeat (3) @(negedge clk);
    #1;
    check(idle_code() == 4, "R1 reset outputs", idle_code(), 4);
    check(ep_sel == 2'b10, "R8 endpoint select", ep_sel, 2);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    #1;
    check(idle_code() == 4, "R1 idle after release", idle_code(), 4);

    // Vector table walk.
    for (int v = 0; v < NV; v++) begin
      base_cap  = cap_n;
      base_ord  = bad_order;
      base_full = bad_full;
      base_gate = bad_gate;
      for (int c = 0; c < VCYC; c++) begin
        @(negedge clk);
        if (c == 0) push_n(VEC[v][0], v);
        if (c == VEC[v][2] && VEC[v][1] > 0) push_n(VEC[v][1], v + 50);
        ctl_full = (c >= VEC[v][3] && c < VEC[v][3] + VEC[v][4]);
        ctl_rdy0 = !((c >= VEC[v][5] && c < VEC[v][5] + VEC[v][6]) && (v % 2 == 0));
        ctl_rdy1 = !((c >= VEC[v][5] && c < VEC[v][5] + VEC[v][6]) && (v % 2 == 1));
      end
      @(negedge clk);
      ctl_full = 1'b0;
      ctl_rdy0 = 1'b1;
      ctl_rdy1 = 1'b1;
      #1;
      check(cap_n - base_cap == VEC[v][0] + VEC[v][1], "R5 bytes written", cap_n - base_cap,
            VEC[v][0] + VEC[v][1]);
      check(bad_order == base_ord, "R5 byte order", bad_order - base_ord, 0);
      check(bad_full == base_full, "R4 strobe under full", bad_full - base_full, 0);
      check(bad_gate == base_gate, "R3 pop gating", bad_gate - base_gate, 0);
      check(idle_code() == 4, "R7 idle after drain", idle_code(), 4);
    end

    // R2: same-cycle pop on leaving idle, then one strobe.
    @(negedge clk);
    push(8'hA5);
    #1;
    check(src_rd == 1'b1 && bus_oe == 1'b0, "R2 pop in idle cycle", {src_rd, bus_oe}, 2);
    @(negedge clk);
    #1;
    check(bus_oe && !wr_n && bus_out == 8'hA5, "R6 strobe with byte", bus_out, 8'hA5);
    check(ep_sel == 2'b10, "R8 select while writing", ep_sel, 2);
    @(negedge clk);
    #1;
    check(idle_code() == 4, "R7 single byte exit", idle_code(), 4);

    // R4: full rises as the popped byte arrives; byte is held then written.
    @(negedge clk);
    push(8'h3C);
    @(negedge clk);
    ctl_full = 1'b1;
    #1;
    check(wr_n && bus_oe, "R4 held under full", {wr_n, bus_oe}, 3);
    repeat (3) @(negedge clk);
    #1;
    check(wr_n && bus_oe, "R4 still held", {wr_n, bus_oe}, 3);
    @(negedge clk);
    ctl_full = 1'b0;
    #1;
    check(!wr_n && bus_out == 8'h3C, "R4 held byte released", bus_out, 8'h3C);
    @(negedge clk);
    #1;
    check(idle_code() == 4, "R7 exit after hold", idle_code(), 4);

    // R3: a low ready flag blocks the start.
    @(negedge clk);
    ctl_rdy1 = 1'b0;
    push(8'h11);
    #1;
    check(src_rd == 1'b0, "R3 no pop while flag low", src_rd, 0);
    repeat (3) @(negedge clk);
    #1;
    check(idle_code() == 4, "R3 stays idle", idle_code(), 4);
    @(negedge clk);
    ctl_rdy1 = 1'b1;
    #1;
    check(src_rd == 1'b1, "R2 start after flag rises", src_rd, 1);
    @(negedge clk);
    #1;
    check(!wr_n && bus_out == 8'h11, "R5 byte after resume", bus_out, 8'h11);
    @(negedge clk);
    #1;
    check(bad_order == 0 && bad_full == 0 && bad_gate == 0, "R5 monitor totals",
          bad_order + bad_full + bad_gate, 0);

    // R1: reset asserted in the middle of a burst.
    @(negedge clk);
    push_n(6, 99);
    repeat (2) @(negedge clk);
    #2;
    rst_n = 1'b0;
    #1;
    check(idle_code() == 4, "R1 async reset mid burst", idle_code(), 4);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    check(src_rd == 1'b0 && bus_out == 8'h00, "R1 release holds idle", {src_rd, bus_out}, 0);
    repeat (4) @(negedge clk);
    #1;
    check(idle_code() == 4, "R1 idle after flush", idle_code(), 4);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule